// File: doc/BRIEF.md
# Password-gated debug access lock

This unit decides whether a debug or in-system programming host may reach each of three program memory segments. Every segment has a lock bit that comes up set after power-on reset. While the lock bit is set, access to that segment stays closed unless the segment's stored password is blank, or unless the host has just presented a matching password. The stored password is not a register. It is the sixteen words that sit at offsets 0x10 through 0x1F above the segment's base address in program memory. Segment 0 is based at address 0. The bases of segments 1 and 2 arrive on input ports.

The host opens an attempt by strobing `start_i` with a segment number. The unit first reads the sixteen stored words through its single memory read port, one read per cycle, and checks whether they are all 0xFFFF or all 0x0000. A mass erase leaves the words at 0xFFFF, so an erased segment is open. If the password is blank, the attempt finishes at once with a grant. Otherwise the unit raises `pw_ready_o` and takes sixteen words from the host, one per accepted `pw_valid_i`. It reads the matching stored word for each one and compares the two. A mismatch in any position fails the attempt. The attempt still takes all sixteen words, so the time it needs does not depend on where the mismatch was.

A grant holds until reset or until that segment's relock strobe. Software can also clear a lock bit directly. That opens the segment with no password.

Top module: `dbg_pw_lock`

## Requirements
- R1: After reset all three lock bits are set, `access_o` is 3'b000, and `busy_o`, `pw_ready_o`, `mem_rd_o` and `done_o` are 0.
- R2: Each memory read addresses base+0x10+i. The base is 0 for segment 0, `base_a_i` for segment 1 and `base_b_i` for segment 2. During the blank scan, i runs 0 to 15 in ascending order, one read per cycle. During comparison, one read is issued per accepted host word, in the same order. Read data is expected one cycle after `mem_rd_o`.
- R3: If all sixteen stored words are 0xFFFF, the attempt needs no host words. `pw_ready_o` never rises. `done_o` and `pass_o` are 1 exactly 17 clock edges after the edge that accepts `start_i`, and the segment's `access_o` bit is 1 from that same cycle.
- R4: If all sixteen stored words are 0x0000, the attempt is likewise treated as blank and is granted as in R3.
- R5: A stored password that mixes 0xFFFF and 0x0000 words is not blank. `pw_ready_o` rises 17 edges after the edge that accepts start.
- R6: For a non-blank password, the unit accepts a word when `pw_valid_i` and `pw_ready_o` are both 1. When all sixteen supplied words equal the stored words in order, `done_o` and `pass_o` are 1 and the segment's `access_o` bit is 1.
- R7: A mismatch at any word position gives `pass_o`=0 with `done_o`, and leaves `access_o` unchanged. In every case `done_o` is a one-cycle pulse that rises exactly one edge after the edge that accepts the sixteenth word.
- R8: A pulse on `lock_clr_i[s]` clears lock bit s, so `access_o[s]` is 1 from the next cycle whatever the password.
- R9: A pulse on `relock_i[s]` sets lock bit s and drops any grant or blank status, so `access_o[s]` is 0 from the next cycle. Relock wins over a simultaneous `lock_clr_i[s]`.
- R10: `start_i` is ignored while `busy_o` is 1, and it is ignored when `seg_sel_i` is 3.
- R11: The segments are independent. An attempt, grant or relock on one segment leaves the other segments' `access_o` bits unchanged. A failed attempt does not remove an earlier grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| base_a_i | input | AW | Base address of segment 1 |
| base_b_i | input | AW | Base address of segment 2 |
| start_i | input | 1 | Opens an unlock attempt |
| seg_sel_i | input | 2 | Segment number for the attempt (0..2) |
| pw_valid_i | input | 1 | Host password word is valid |
| pw_data_i | input | DW | Host password word |
| pw_ready_o | output | 1 | Unit is taking host password words |
| lock_clr_i | input | 3 | Per-segment strobe that clears the lock bit |
| relock_i | input | 3 | Per-segment strobe that sets the lock bit and drops the grant |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data, one cycle after the request |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | One-cycle pulse when an attempt finishes |
| pass_o | output | 1 | Result of the last finished attempt |
| access_o | output | 3 | Per-segment access granted |

## Verification
The bench uses AW=8 with segment bases 0x40 and 0x80, so the three password windows fit in a 256-word memory model. With this layout, a read outside the expected window stands out, and the total read count can be checked for each attempt. DW stays at 16 and PW_WORDS at 16, so the blank patterns are the real 0xFFFF and 0x0000 values. The fixed 17-edge scan latency and the one-edge finish after the last word are checked directly. Stored patterns change with segment and word index, so a read in the wrong order or from the wrong base shows up as a miscompare. Mismatches are placed at the first, a middle and the last word position.

// File: rtl/dbg_lock_pkg.sv
package dbg_lock_pkg;

  localparam int unsigned NSEG  = 3;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_SCAN    = 3'd1,
    SQ_SDRAIN  = 3'd2,
    SQ_COLLECT = 3'd3,
    SQ_CDRAIN  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/dbg_lock_seq.sv
module dbg_lock_seq
  import dbg_lock_pkg::*;
#(
  parameter int unsigned PW_WORDS = 16,
  localparam int unsigned IDX_W = $clog2(PW_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             pw_valid,
  input  logic             blank_final,
  output logic             busy,
  output logic             pw_ready,
  output logic             mem_rd,
  output logic             scan_rd,
  output logic             word_take,
  output logic [IDX_W-1:0] rd_idx,
  output logic             scan_fin,
  output logic             cmp_fin
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PW_WORDS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign busy      = (state_q != SQ_IDLE);
  assign pw_ready  = (state_q == SQ_COLLECT);
  assign word_take = pw_ready && pw_valid;
  assign scan_rd   = (state_q == SQ_SCAN);
  assign mem_rd    = scan_rd || word_take;
  assign rd_idx    = idx_q;
  assign scan_fin  = (state_q == SQ_SDRAIN);
  assign cmp_fin   = (state_q == SQ_CDRAIN);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_ok) begin
          state_d = SQ_SCAN;
          idx_d   = '0;
        end
      end
      SQ_SCAN: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) state_d = SQ_SDRAIN;
      end
      SQ_SDRAIN: begin
        idx_d   = '0;
        state_d = blank_final ? SQ_IDLE : SQ_COLLECT;
      end
      SQ_COLLECT: begin
        if (word_take) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_d = SQ_CDRAIN;
        end
      end
      SQ_CDRAIN: begin
        state_d = SQ_IDLE;
        idx_d   = '0;
      end
      default: begin
        state_d = SQ_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // Comparison always ends right after a word was taken: fixed finish timing.
  assert_cmp_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fin |-> $past(word_take));

  // A blank decision never leaves the unit waiting for host words.
  assert_blank_no_collect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fin && blank_final) |=> !pw_ready);

endmodule

// File: rtl/dbg_lock_eval.sv
module dbg_lock_eval #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          mem_rd,
  input  logic          scan_rd,
  input  logic          word_take,
  input  logic [DW-1:0] pw_data,
  input  logic [DW-1:0] rdata,
  output logic          blank_final,
  output logic          match_final
);

  function automatic logic word_all_ones(input logic [DW-1:0] w);
    return &w;
  endfunction

  function automatic logic word_all_zeros(input logic [DW-1:0] w);
    return ~|w;
  endfunction

  function automatic logic word_differs(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return |(a ^ b);
  endfunction

  logic          pend_q, pend_scan_q;
  logic [DW-1:0] pw_q;
  logic          ones_q, zeros_q, mism_q;
  logic          ones_d, zeros_d, mism_d;
  logic          scan_beat, cmp_beat;

  assign scan_beat = pend_q && pend_scan_q;
  assign cmp_beat  = pend_q && !pend_scan_q;

  always_comb begin
    ones_d  = ones_q  && (!scan_beat || word_all_ones(rdata));
    zeros_d = zeros_q && (!scan_beat || word_all_zeros(rdata));
    mism_d  = mism_q  || (cmp_beat && word_differs(rdata, pw_q));
  end

  assign blank_final = ones_d || zeros_d;
  assign match_final = !mism_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_scan_q <= 1'b0;
      pw_q        <= '0;
      ones_q      <= 1'b1;
      zeros_q     <= 1'b1;
      mism_q      <= 1'b0;
    end else begin
      pend_q      <= mem_rd;
      pend_scan_q <= scan_rd;
      if (word_take) pw_q <= pw_data;
      if (clear) begin
        ones_q  <= 1'b1;
        zeros_q <= 1'b1;
        mism_q  <= 1'b0;
      end else begin
        ones_q  <= ones_d;
        zeros_q <= zeros_d;
        mism_q  <= mism_d;
      end
    end
  end

  // Once a stored word has been seen, it cannot count as both kinds of blank.
  assert_blank_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_beat && !clear) |=> !(ones_q && zeros_q));

endmodule

// File: rtl/dbg_lock_bank.sv
module dbg_lock_bank #(
  parameter int unsigned NSEG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEG-1:0] lock_clr,
  input  logic [NSEG-1:0] relock,
  input  logic [NSEG-1:0] set_blank,
  input  logic [NSEG-1:0] set_grant,
  output logic [NSEG-1:0] access
);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic lock_q, blank_q, grant_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q  <= 1'b1;
        blank_q <= 1'b0;
        grant_q <= 1'b0;
      end else if (relock[s]) begin
        lock_q  <= 1'b1;
        blank_q <= 1'b0;
        grant_q <= 1'b0;
      end else begin
        if (lock_clr[s])  lock_q  <= 1'b0;
        if (set_blank[s]) blank_q <= 1'b1;
        if (set_grant[s]) grant_q <= 1'b1;
      end
    end

    assign access[s] = !lock_q || blank_q || grant_q;

    assert_relock_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      relock[s] |=> !access[s]);

    assert_clear_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_clr[s] && !relock[s]) |=> access[s]);
  end

endmodule

// File: rtl/dbg_pw_lock.sv
module dbg_pw_lock
  import dbg_lock_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned PW_WORDS  = 16,
  parameter int unsigned PW_OFFSET = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   base_a_i,
  input  logic [AW-1:0]   base_b_i,
  input  logic            start_i,
  input  logic [1:0]      seg_sel_i,
  input  logic            pw_valid_i,
  input  logic [DW-1:0]   pw_data_i,
  output logic            pw_ready_o,
  input  logic [2:0]      lock_clr_i,
  input  logic [2:0]      relock_i,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            pass_o,
  output logic [2:0]      access_o
);

  localparam int unsigned IDX_W = $clog2(PW_WORDS);

  function automatic logic [AW-1:0] seg_base(input logic [SEL_W-1:0] seg,
                                             input logic [AW-1:0] ba,
                                             input logic [AW-1:0] bb);
    case (seg)
      2'd1:    return ba;
      2'd2:    return bb;
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] pw_addr(input logic [AW-1:0] base,
                                            input logic [IDX_W-1:0] idx);
    return base + AW'(PW_OFFSET) + AW'(idx);
  endfunction

  // Named internal events
  logic             start_ok;
  logic             scan_rd, word_take, scan_fin, cmp_fin;
  logic             blank_final, match_final;
  logic [IDX_W-1:0] rd_idx;
  logic [SEL_W-1:0] seg_q;
  logic [AW-1:0]    base_sel;
  logic [NSEG-1:0]  seg_hot, set_blank, set_grant;
  logic             blank_hit;
  logic             done_q, pass_q;

  assign start_ok  = start_i && !busy_o && (seg_sel_i < SEL_W'(NSEG));
  assign blank_hit = scan_fin && blank_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else if (start_ok) seg_q <= seg_sel_i;
  end

  assign base_sel   = seg_base(seg_q, base_a_i, base_b_i);
  assign mem_addr_o = pw_addr(base_sel, rd_idx);

  for (genvar g = 0; g < NSEG; g++) begin : g_hot
    assign seg_hot[g] = (seg_q == SEL_W'(g));
  end

  assign set_blank = blank_hit ? seg_hot : '0;
  assign set_grant = (cmp_fin && match_final) ? seg_hot : '0;

  dbg_lock_seq #(.PW_WORDS(PW_WORDS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .pw_valid   (pw_valid_i),
    .blank_final(blank_final),
    .busy       (busy_o),
    .pw_ready   (pw_ready_o),
    .mem_rd     (mem_rd_o),
    .scan_rd    (scan_rd),
    .word_take  (word_take),
    .rd_idx     (rd_idx),
    .scan_fin   (scan_fin),
    .cmp_fin    (cmp_fin)
  );

  dbg_lock_eval #(.DW(DW)) i_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .mem_rd     (mem_rd_o),
    .scan_rd    (scan_rd),
    .word_take  (word_take),
    .pw_data    (pw_data_i),
    .rdata      (mem_rdata_i),
    .blank_final(blank_final),
    .match_final(match_final)
  );

  dbg_lock_bank #(.NSEG(NSEG)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_clr (lock_clr_i),
    .relock   (relock_i),
    .set_blank(set_blank),
    .set_grant(set_grant),
    .access   (access_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= blank_hit || cmp_fin;
      if (blank_hit)    pass_q <= 1'b1;
      else if (cmp_fin) pass_q <= match_final;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // Window check on every memory read.
  logic [AW-1:0] rel_addr;
  assign rel_addr = mem_addr_o - base_sel;

  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (rel_addr >= AW'(PW_OFFSET)) && (rel_addr < AW'(PW_OFFSET + PW_WORDS)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_fail_keeps_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !pass_o && ($past(relock_i) == '0) && ($past(lock_clr_i) == '0))
      |-> $stable(access_o));

  assert_pass_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pass_o && ($past(relock_i) == '0)) |-> ((access_o & seg_hot) == seg_hot));

  assert_busy_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> $stable(seg_q));

endmodule

// File: tb/test_dbg_pw_lock.sv
module test_dbg_pw_lock;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] BASE_A = 8'h40;
  localparam logic [AW-1:0] BASE_B = 8'h80;

  typedef struct packed {
    logic [1:0] seg;
    logic [1:0] kind;   // 0 all-ones, 1 all-zeros, 2 pattern, 3 mixed blank words
    logic [4:0] bad;    // index of wrong word, 16 = none
    logic       clr;
    logic       ep;
    logic       ea;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 5'd16, 1'b0, 1'b1, 1'b1},
    '{2'd0, 2'd2, 5'd0,  1'b0, 1'b0, 1'b0},
    '{2'd1, 2'd2, 5'd15, 1'b0, 1'b0, 1'b0},
    '{2'd1, 2'd2, 5'd16, 1'b0, 1'b1, 1'b1},
    '{2'd2, 2'd2, 5'd7,  1'b0, 1'b0, 1'b0},
    '{2'd2, 2'd2, 5'd16, 1'b0, 1'b1, 1'b1},
    '{2'd1, 2'd0, 5'd16, 1'b0, 1'b1, 1'b1},
    '{2'd2, 2'd1, 5'd16, 1'b0, 1'b1, 1'b1},
    '{2'd0, 2'd3, 5'd16, 1'b0, 1'b1, 1'b1},
    '{2'd0, 2'd3, 5'd3,  1'b0, 1'b0, 1'b0},
    '{2'd1, 2'd2, 5'd5,  1'b1, 1'b0, 1'b1},
    '{2'd0, 2'd1, 5'd16, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] seg_sel_i = '0;
  logic pw_valid_i = 1'b0;
  logic [DW-1:0] pw_data_i = '0;
  logic [2:0] lock_clr_i = '0;
  logic [2:0] relock_i = '0;
  logic [DW-1:0] mem_rdata_i;
  logic pw_ready_o, mem_rd_o, busy_o, done_o, pass_o;
  logic [AW-1:0] mem_addr_o;
  logic [2:0] access_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [DW-1:0] mem [256];
  logic [AW-1:0] cur_base = '0;
  int nreads = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_pw_lock #(.AW(AW), .DW(DW)) i_dbg_pw_lock (
    .clk(clk), .rst_n(rst_n), .base_a_i(BASE_A), .base_b_i(BASE_B),
    .start_i(start_i), .seg_sel_i(seg_sel_i), .pw_valid_i(pw_valid_i),
    .pw_data_i(pw_data_i), .pw_ready_o(pw_ready_o), .lock_clr_i(lock_clr_i),
    .relock_i(relock_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .access_o(access_o)
  );

  // Memory model: one cycle read latency; counts reads and reads outside the window (R2)
  always_ff @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= mem[mem_addr_o];
      nreads <= nreads + 1;
      if (mem_addr_o < cur_base + 8'h10 || mem_addr_o > cur_base + 8'h1F) nbad <= nbad + 1;
    end
  end

  function automatic logic [AW-1:0] base_of(input logic [1:0] seg);
    return (seg == 2'd1) ? BASE_A : (seg == 2'd2) ? BASE_B : '0;
  endfunction

  function automatic logic [DW-1:0] stored_word(input logic [1:0] seg, input logic [1:0] kind, input int i);
    case (kind)
      2'd0: return 16'hFFFF;
      2'd1: return 16'h0000;
      2'd2: return 16'h3C00 + 16'(seg) * 16'h1111 + 16'(i) * 16'h0107;
      default: return (i % 2 == 0) ? 16'hFFFF : 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] seg, input logic [1:0] kind);
    for (int i = 0; i < 16; i++) mem[base_of(seg) + 8'h10 + 8'(i)] = stored_word(seg, kind, i);
  endtask

  task automatic pulse_relock(input logic [2:0] m);
    relock_i = m;
    @(posedge clk); @(negedge clk);
    relock_i = '0;
  endtask

  // Run one attempt; words are wrong at index bad (16 = all correct)
  task automatic attempt(input logic [1:0] seg, input logic [1:0] kind, input int bad,
                         input string req, output logic got_pass);
    int n;
    int r0;
    r0 = nreads;
    cur_base = base_of(seg);
    seg_sel_i = seg; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && !pw_ready_o && n < 40) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk({req, " scan latency R3"}, n, 17);
    if (kind < 2) begin
      chk({req, " blank done R3 R4"}, {pw_ready_o, done_o}, 2'b01);
      chk({req, " blank reads R2"}, nreads - r0, 16);
    end else begin
      chk({req, " nonblank ready R5"}, {pw_ready_o, done_o}, 2'b10);
      for (int i = 0; i < 16; i++) begin
        pw_valid_i = 1'b1;
        pw_data_i = stored_word(seg, kind, i) ^ ((i == bad) ? 16'h0001 : 16'h0000);
        @(posedge clk); @(negedge clk);
      end
      pw_valid_i = 1'b0;
      chk({req, " no early done R7"}, done_o, 1'b0);
      @(posedge clk); @(negedge clk);
      chk({req, " done after last word R7"}, done_o, 1'b1);
      chk({req, " compare reads R2"}, nreads - r0, 32);
    end
    got_pass = pass_o;
  endtask

  initial begin
    logic p;
    for (int a = 0; a < 256; a++) mem[a] = 16'h5A5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 access", access_o, 3'b000);
    chk("R1 idle outputs", {busy_o, pw_ready_o, mem_rd_o, done_o}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 access after release", access_o, 3'b000);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      pulse_relock(3'b111);
      load(VECS[v].seg, VECS[v].kind);
      if (VECS[v].clr) begin
        lock_clr_i = 3'b001 << VECS[v].seg;
        @(posedge clk); @(negedge clk);
        lock_clr_i = '0;
        chk($sformatf("vec%0d R8 clear opens", v), access_o, 3'b001 << VECS[v].seg);
      end
      attempt(VECS[v].seg, VECS[v].kind, VECS[v].bad, $sformatf("vec%0d", v), p);
      chk($sformatf("vec%0d pass R6 R7", v), p, VECS[v].ep);
      chk($sformatf("vec%0d access R11", v), access_o, VECS[v].ea ? (3'b001 << VECS[v].seg) : 3'b000);
      @(negedge clk);
      chk($sformatf("vec%0d done pulse R7", v), done_o, 1'b0);
    end

    // R11 grant survives a failed attempt, other segments untouched
    pulse_relock(3'b111);
    load(2'd1, 2'd2);
    attempt(2'd1, 2'd2, 16, "persist ok", p);
    attempt(2'd1, 2'd2, 9, "persist bad", p);
    chk("R11 failed attempt keeps grant", {p, access_o}, {1'b0, 3'b010});

    // R9 relock drops grant; relock beats lock clear
    relock_i = 3'b010;
    @(posedge clk); @(negedge clk);
    relock_i = '0;
    chk("R9 relock closes", access_o, 3'b000);
    lock_clr_i = 3'b100; relock_i = 3'b100;
    @(posedge clk); @(negedge clk);
    lock_clr_i = '0; relock_i = '0;
    chk("R9 relock wins", access_o, 3'b000);
    lock_clr_i = 3'b001;
    @(posedge clk); @(negedge clk);
    lock_clr_i = '0;
    chk("R8 lock clear alone", access_o, 3'b001);

    // R10 segment 3 ignored
    seg_sel_i = 2'd3; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk("R10 seg3 ignored", {busy_o, mem_rd_o}, 2'b00);

    // R10 start while busy ignored: blank scan on seg 2, second start on seg 1
    pulse_relock(3'b111);
    load(2'd2, 2'd0);
    cur_base = BASE_B;
    seg_sel_i = 2'd2; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    seg_sel_i = 2'd1;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    start_i = 1'b0;
    repeat (13) begin @(posedge clk); @(negedge clk); end
    chk("R10 busy start ignored", {done_o, pass_o, access_o}, {2'b11, 3'b100});
    @(negedge clk);
    chk("R10 no second attempt", busy_o, 1'b0);
    chk("R2 no reads out of window", nbad, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule